// File: doc/BRIEF.md
# OFDM Packet Start Qualifier

This block decides the moment at which an OFDM receiver begins to process a packet. It takes short-correlation detect pulses from an internal detector and from an external input, and threshold-crossing pulses from a long correlator. A parallel control word chooses which short sources are enabled and which conditions a packet start must meet. The block emits a one-cycle start pulse and, on request, a strobe that tells the frequency-offset stage to capture its estimate on the long training symbols.

A short detect arms the block for a programmable window. In two-crossing mode the block needs a second long crossing spaced exactly 64 cycles from the first. A crossing at any other spacing becomes the new reference instead. After a start the block ignores every detector input until a packet-done pulse or a reset returns it to idle.

Top module: `ofdm_pkt_qual`

## Requirements
- R1: Control bit 8 enables the internal short detector and bit 7 enables the external one. A pulse from a disabled source never arms the block and never starts a packet.
- R2: With bit 6 set and bit 1 or bit 5 set, a start happens only when a long qualification event arrives while the block is armed by an earlier enabled short detect. A long crossing with no such detect starts nothing.
- R3: With bit 6 clear, a long qualification event alone starts a packet whatever bit 1 is. A short detect alone starts nothing.
- R4: With bit 6 set and bits 1 and 5 both clear, an enabled short detect starts a packet by itself.
- R5: With bit 5 set, a long qualification event is a crossing that comes exactly SPACING (64) cycles after the reference crossing. A second crossing 63 or 65 cycles after the first does not qualify.
- R6: A short detect keeps the block armed for ARM_WIN cycles (default 320). A long event 1 to ARM_WIN cycles after the detect may start a packet. A long event ARM_WIN+1 or more cycles after it may not.
- R7: In two-crossing mode a crossing at the wrong spacing becomes the new reference, and the 64-cycle count restarts from it.
- R8: After a start, all detector inputs are ignored until pkt_done is seen. The block is then idle and can start again.
- R9: `sop` is high for exactly one cycle. It goes high in the cycle after the qualifying input.
- R10: `cfo_capture` goes high together with `sop` only when bit 12 is set and the start was caused by a long qualification event. Otherwise it stays low.
- R11: Synchronous active-high `rst` clears the armed window, the crossing reference and the started state. Both outputs are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | CTRL_W | Control word. Bits 12, 8, 7, 6, 5 and 1 are used. |
| short_int | input | 1 | Internal short-correlation detect pulse |
| short_ext | input | 1 | External packet-detect pulse |
| long_xing | input | 1 | Long-correlator threshold crossing pulse |
| pkt_done | input | 1 | Ends the current packet and returns the block to idle |
| sop | output | 1 | Start-of-packet pulse |
| cfo_capture | output | 1 | Strobe to capture the frequency-offset estimate |

## Verification
Both `sop` and `cfo_capture` are registered, so each one is due at the rising edge that closes the cycle in which the qualifying pulse is held. The bench drives every input on the falling edge and holds it for exactly one cycle. It reads the outputs one time unit after the next rising edge, so each check looks at the result of one known input cycle. Spacing and window sweeps count idle cycles from the reference pulse, and the expected outcome comes from comparing that count with SPACING or ARM_WIN.

// File: rtl/pq_pkg.sv
package pq_pkg;
  localparam int CB_CFO_LONG  = 12;
  localparam int CB_INT_EN    = 8;
  localparam int CB_EXT_EN    = 7;
  localparam int CB_REQ_SHORT = 6;
  localparam int CB_REQ_TWO   = 5;
  localparam int CB_REQ_LONG  = 1;

  typedef struct packed {
    logic cfo_long;
    logic int_en;
    logic ext_en;
    logic req_short;
    logic req_two;
    logic req_long;
  } qual_cfg_t;

  function automatic qual_cfg_t decode_cfg(input logic [12:0] w);
    qual_cfg_t c;
    c.cfo_long  = w[CB_CFO_LONG];
    c.int_en    = w[CB_INT_EN];
    c.ext_en    = w[CB_EXT_EN];
    c.req_short = w[CB_REQ_SHORT];
    c.req_two   = w[CB_REQ_TWO];
    c.req_long  = w[CB_REQ_LONG];
    return c;
  endfunction
endpackage

// File: rtl/pq_short_arm.sv
module pq_short_arm #(
  parameter int ARM_WIN = 320
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic evt,
  output logic armed
);
  localparam int CW = $clog2(ARM_WIN + 1);
  localparam logic [CW-1:0] WIN_LD = CW'(ARM_WIN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clr)       remain <= '0;
    else if (evt)         remain <= WIN_LD;
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign armed = (remain != 0);

  // R6: arming only ever starts from a short detect
  a_r6_arm_from_event: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(evt));
  // R11: a clear drops the window
  a_r11_clear_drops: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !armed);
endmodule

// File: rtl/pq_long_gap.sv
module pq_long_gap #(
  parameter int SPACING = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic xing,
  output logic qual
);
  localparam int GW = $clog2(SPACING + 2);
  localparam logic [GW-1:0] GAP_HIT = GW'(SPACING);
  localparam logic [GW-1:0] GAP_TOP = GW'(SPACING + 1);

  logic          ref_valid;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ref_valid <= 1'b0;
      gap       <= '0;
    end else if (xing) begin
      ref_valid <= 1'b1;
      gap       <= GW'(1);
    end else if (ref_valid && gap != GAP_TOP) begin
      gap <= gap + 1'b1;
    end
  end

  assign qual = xing && ref_valid && (gap == GAP_HIT);

  // R7: any crossing that is not cleared becomes the reference
  a_r7_ref_after_xing: assert property (@(posedge clk) disable iff (rst)
    (xing && !clr) |=> ref_valid);
  // R5: the spacing counter never runs past its saturation value
  a_r5_gap_bounded: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_TOP);
endmodule

// File: rtl/pq_start_ctl.sv
module pq_start_ctl
  import pq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  qual_cfg_t cfg,
  input  logic      short_evt,
  input  logic      armed,
  input  logic      long_xing,
  input  logic      long_qual,
  input  logic      pkt_done,
  output logic      clr,
  output logic      sop,
  output logic      cfo_capture
);
  logic locked;
  logic need_long;
  logic long_evt;
  logic start_now;

  assign need_long = cfg.req_long | cfg.req_two;
  assign long_evt  = cfg.req_two ? long_qual : long_xing;

  always_comb begin
    start_now = 1'b0;
    if (!locked && !pkt_done) begin
      if (cfg.req_short) start_now = need_long ? (armed && long_evt) : short_evt;
      else               start_now = long_evt;
    end
  end

  assign clr = locked | pkt_done | start_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked      <= 1'b0;
      sop         <= 1'b0;
      cfo_capture <= 1'b0;
    end else begin
      sop         <= start_now;
      cfo_capture <= start_now && cfg.cfo_long && long_evt;
      if (pkt_done)       locked <= 1'b0;
      else if (start_now) locked <= 1'b1;
    end
  end

  // R9: start pulse lasts one cycle
  a_r9_sop_single: assert property (@(posedge clk) disable iff (rst)
    sop |=> !sop);
  // R10: capture strobe only accompanies a start
  a_r10_cfo_with_sop: assert property (@(posedge clk) disable iff (rst)
    cfo_capture |-> sop);
  // R8: a start leaves the block locked
  a_r8_locked_after_sop: assert property (@(posedge clk) disable iff (rst)
    sop |-> locked);
  // R8: no start while already locked
  a_r8_quiet_when_locked: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> !sop);
endmodule

// File: rtl/ofdm_pkt_qual.sv
module ofdm_pkt_qual
  import pq_pkg::*;
#(
  parameter int CTRL_W  = 16,
  parameter int SPACING = 64,
  parameter int ARM_WIN = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              short_int,
  input  logic              short_ext,
  input  logic              long_xing,
  input  logic              pkt_done,
  output logic              sop,
  output logic              cfo_capture
);
  qual_cfg_t cfg;
  logic      short_evt;
  logic      armed;
  logic      long_qual;
  logic      clr;
  logic      unused_ctrl;

  assign cfg         = decode_cfg(ctrl[12:0]);
  assign unused_ctrl = ^ctrl;
  // R1: only enabled sources count as a short detect
  assign short_evt   = (short_int & cfg.int_en) | (short_ext & cfg.ext_en);

  pq_short_arm #(.ARM_WIN(ARM_WIN)) arm_i (
    .clk(clk), .rst(rst), .clr(clr), .evt(short_evt), .armed(armed)
  );

  pq_long_gap #(.SPACING(SPACING)) gap_i (
    .clk(clk), .rst(rst), .clr(clr), .xing(long_xing), .qual(long_qual)
  );

  pq_start_ctl ctl_i (
    .clk(clk), .rst(rst), .cfg(cfg), .short_evt(short_evt), .armed(armed),
    .long_xing(long_xing), .long_qual(long_qual), .pkt_done(pkt_done),
    .clr(clr), .sop(sop), .cfo_capture(cfo_capture)
  );

  // R1: a pulse from a disabled source alone never starts a packet in short-only mode
  a_r1_disabled_ignored: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg.req_short && !cfg.req_long && !cfg.req_two && !short_evt && !long_xing)
     && $past(!pkt_done)) |-> !sop);
endmodule

// File: tb/ofdm_pkt_qual_tb.sv
`timescale 1ns/1ps
module ofdm_pkt_qual_tb_top;
  localparam int CLK_P = 10;
  localparam int SP    = 64;
  localparam int W     = 12;
  localparam logic [15:0] B_CFO = 16'h1000, B_INT = 16'h0100, B_EXT = 16'h0080,
                          B_RS  = 16'h0040, B_TWO = 16'h0020, B_RL  = 16'h0002;

  logic clk = 1'b0, rst = 1'b1;
  logic [15:0] ctrl = '0;
  logic si = 0, se = 0, lx = 0, pd = 0;
  logic sop, cfo;
  logic got_sop, got_cfo;
  int checks = 0, failures = 0;

  ofdm_pkt_qual #(.CTRL_W(16), .SPACING(SP), .ARM_WIN(W)) dut_i (
    .clk(clk), .rst(rst), .ctrl(ctrl), .short_int(si), .short_ext(se),
    .long_xing(lx), .pkt_done(pd), .sop(sop), .cfo_capture(cfo)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic cyc(input logic i, input logic e, input logic l, input logic d);
    @(negedge clk);
    si = i; se = e; lx = l; pd = d;
    @(posedge clk);
    #1;
    got_sop = sop; got_cfo = cfo;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0);
  endtask

  task automatic do_reset(input logic [15:0] c);
    @(negedge clk);
    rst = 1; ctrl = c; si = 0; se = 0; lx = 0; pd = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R11 reset state
    do_reset(B_RS | B_INT);
    idle(1);
    chk("R11 reset sop", sop, 0);
    chk("R11 reset cfo", cfo, 0);

    // R1 / R4: enable sweep, short-only mode
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 2; s++) begin
        logic en;
        do_reset(B_RS | (m[0] ? B_INT : 16'h0) | (m[1] ? B_EXT : 16'h0));
        en = (s == 0) ? m[0] : m[1];
        cyc(s == 0, s == 1, 0, 0);
        chk("R1 R4 enabled short starts", got_sop, en);
      end
    end

    // R1: disabled source does not arm in short+long mode
    do_reset(B_RS | B_RL | B_INT);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    chk("R1 disabled source no arm", got_sop, 0);

    // R2: long alone no start; short then long starts
    do_reset(B_RS | B_RL | B_INT | B_CFO);
    cyc(0, 0, 1, 0);
    chk("R2 long without short", got_sop, 0);
    cyc(1, 0, 0, 0);
    chk("R2 short alone pending", got_sop, 0);
    idle(4);
    cyc(0, 0, 1, 0);
    chk("R2 short then long", got_sop, 1);
    chk("R10 cfo on long start", got_cfo, 1);
    cyc(0, 0, 0, 0);
    chk("R9 sop one cycle", got_sop, 0);

    // R6: window sweep
    for (int d = 1; d <= W + 3; d++) begin
      do_reset(B_RS | B_RL | B_EXT);
      cyc(0, 1, 0, 0);
      idle(d - 1);
      cyc(0, 0, 1, 0);
      chk("R6 arm window", got_sop, d <= W);
    end

    // R3: long alone starts without short requirement
    do_reset(B_RL);
    cyc(0, 0, 1, 0);
    chk("R3 long alone bit1 set", got_sop, 1);
    chk("R10 cfo clear without bit12", got_cfo, 0);
    do_reset(16'h0);
    cyc(0, 0, 1, 0);
    chk("R3 long alone bit1 clear", got_sop, 1);
    do_reset(B_INT | B_EXT);
    cyc(1, 1, 0, 0);
    chk("R3 short alone no start", got_sop, 0);

    // R10: short-only start with bit12 gives no capture
    do_reset(B_RS | B_INT | B_CFO);
    cyc(1, 0, 0, 0);
    chk("R10 short start sop", got_sop, 1);
    chk("R10 short start no cfo", got_cfo, 0);

    // R5: spacing sweep
    for (int s = SP - 4; s <= SP + 4; s++) begin
      do_reset(B_TWO | B_CFO);
      cyc(0, 0, 1, 0);
      if (s == SP - 4) chk("R5 first crossing alone", got_sop, 0);
      idle(s - 1);
      cyc(0, 0, 1, 0);
      chk("R5 exact spacing", got_sop, s == SP);
      if (s == SP) chk("R10 cfo two-crossing", got_cfo, 1);
    end

    // R7: wrong spacing becomes new reference
    do_reset(B_TWO);
    cyc(0, 0, 1, 0);
    idle(29);
    cyc(0, 0, 1, 0);
    chk("R7 wrong spacing no start", got_sop, 0);
    idle(SP - 31);
    cyc(0, 0, 1, 0);
    chk("R7 old reference dropped", got_sop, 0);
    do_reset(B_TWO);
    cyc(0, 0, 1, 0);
    idle(29);
    cyc(0, 0, 1, 0);
    idle(SP - 1);
    cyc(0, 0, 1, 0);
    chk("R7 new reference qualifies", got_sop, 1);

    // R8: locked until pkt_done
    do_reset(B_RL | B_INT);
    cyc(0, 0, 1, 0);
    chk("R8 first start", got_sop, 1);
    for (int k = 0; k < 6; k++) cyc(1, 1, 1, 0);
    chk("R8 inputs ignored while locked", got_sop, 0);
    cyc(0, 0, 1, 1);
    chk("R8 pkt_done cycle no start", got_sop, 0);
    cyc(0, 0, 1, 0);
    chk("R8 start again after done", got_sop, 1);

    // R11: reset mid-arm and mid-spacing
    do_reset(B_RS | B_RL | B_INT);
    cyc(1, 0, 0, 0);
    do_reset(B_RS | B_RL | B_INT);
    cyc(0, 0, 1, 0);
    chk("R11 reset drops arm", got_sop, 0);
    do_reset(B_TWO);
    cyc(0, 0, 1, 0);
    idle(10);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    idle(SP - 13);
    cyc(0, 0, 1, 0);
    chk("R11 reset drops reference", got_sop, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule